// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Bank

The timer bank holds several independent down-counters behind a small word-addressed register port. Each channel has a load register that sets the count directly, a staged reload register that is only picked up when the count next passes through zero, a control register, and a readable current value. A channel runs in one of three modes. Free-running mode wraps to all ones. Periodic mode reloads from the staged value. One-shot mode halts at zero and switches itself off. A per-channel prescaler divides the clock by 1, 16 or 256 before the count moves.

Each channel raises a raw event flag on the tick that brings its count to zero. All channels share one interrupt bank: an enable mask, the raw flags, the masked flags and a write-one-to-clear register. A single interrupt line is the OR of the masked flags. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `cdt_timer_bank`

## Requirements
- R1: After reset every register reads zero, except that each channel's current value reads 0xFFFFFFFF. The interrupt output is low.
- R2: Word 0x00 is the interrupt enable mask, 0x04 the raw flags (read-only), 0x08 the masked flags (read-only) and 0x0C the clear register (reads zero). Channel n occupies 0x10+0x10*n with load at +0, current value at +4, control at +8 and staged reload at +0xC. Load and staged reload read back the written word. Control keeps only bits 7, 6, 3:2, 1 and 0, so writing 0xFF reads 0xCF.
- R3: A load write sets the current value at the next edge. The value is masked to the low 16 bits when control bit 1 is clear. The write also restarts the prescaler, and the first decrement follows D cycles later, where D is the divide ratio.
- R4: Control bits 3:2 choose the divide ratio: 00 gives 1, 01 gives 16, and both 10 and 11 give 256. The prescaler also restarts when bit 7 goes from 0 to 1.
- R5: Free-running mode is bits 6 and 0 both clear. On the tick after the count reaches zero, it wraps to 0xFFFFFFFF when bit 1 is set and to 0x0000FFFF when bit 1 is clear.
- R6: Periodic mode is bit 6 set with bit 0 clear. On the tick after zero, the count reloads from the staged reload register. A write to the staged reload register never changes the current value.
- R7: One-shot mode is bit 0 set, and it takes precedence over bit 6. The count stays at zero. On the tick that reaches zero, hardware clears enable bit 7, unless a control write happens in the same cycle.
- R8: Raw flag bit n is set by channel n on the tick in which its count reaches zero. Writing 1 to bit n of the clear register resets the flag. A set in the same cycle wins over the clear.
- R9: The masked flags equal the raw flags ANDed with the mask. The interrupt output is high exactly when any masked flag is set.
- R10: While bit 7 is clear and no load is written, the current value holds.
- R11: Channels are independent, so activity on one channel leaves the others' values unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register word |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data for bus_addr, combinational |
| irq | output | 1 | OR of all masked interrupt flags |

## Verification
A register write lands at the edge that ends its cycle. Read data and the interrupt output follow combinationally, so they can be checked in the next low phase of the clock. A running channel with divide ratio D first moves D edges after the edge that wrote its load or set its enable. It then moves every D edges. It reaches zero, and raises its raw flag, on tick number V for a loaded value V. It wraps or reloads one tick after that. The bench counts whole clock cycles from each write to the tick where a change is due. It checks one cycle before the change (value unchanged) and exactly at it, so an early or late tick shows as an error. Expected values are queued by the driver and compared by a monitor in the same low phase, before the next edge.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

   localparam int CTRL_W     = 8;
   localparam int CTRL_EN    = 7;
   localparam int CTRL_PER   = 6;
   localparam int CTRL_PS_HI = 3;
   localparam int CTRL_PS_LO = 2;
   localparam int CTRL_WIDE  = 1;
   localparam int CTRL_ONE   = 0;
   localparam logic [CTRL_W-1:0] CTRL_KEEP = 8'hCF;

   // word index inside the shared group and inside a channel group
   localparam logic [1:0] SH_MASK = 2'd0;
   localparam logic [1:0] SH_RAW  = 2'd1;
   localparam logic [1:0] SH_MIS  = 2'd2;
   localparam logic [1:0] SH_CLR  = 2'd3;

   localparam logic [1:0] CH_LOAD = 2'd0;
   localparam logic [1:0] CH_VAL  = 2'd1;
   localparam logic [1:0] CH_CTRL = 2'd2;
   localparam logic [1:0] CH_BG   = 2'd3;

   typedef enum logic [1:0] {
      MODE_FREE     = 2'd0,
      MODE_PERIODIC = 2'd1,
      MODE_ONESHOT  = 2'd2
   } cdt_mode_e;

   function automatic cdt_mode_e mode_of(input logic [CTRL_W-1:0] c);
      if (c[CTRL_ONE])      return MODE_ONESHOT;
      else if (c[CTRL_PER]) return MODE_PERIODIC;
      else                  return MODE_FREE;
   endfunction

endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
   parameter int MID_LOG = 4,
   parameter int MAX_LOG = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       run,
   input  logic [1:0] div,
   output logic       tick
);

   if (MID_LOG < 1 || MID_LOG >= MAX_LOG) begin : g_bad_log
      $error("cdt_prescaler: need 1 <= MID_LOG < MAX_LOG");
   end

   logic [MAX_LOG-1:0] pcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pcnt <= '0;
      else if (restart) pcnt <= '0;
      else if (run)     pcnt <= pcnt + 1'b1;
   end

   always_comb begin
      unique case (div)
         2'b00:   tick = run;
         2'b01:   tick = run && (&pcnt[MID_LOG-1:0]);
         default: tick = run && (&pcnt);
      endcase
   end

endmodule

// File: rtl/cdt_channel.sv
module cdt_channel
   import cdt_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int NARROW_W   = 16,
   parameter int PS_MID_LOG = 4,
   parameter int PS_MAX_LOG = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_load,
   input  logic              wr_ctrl,
   input  logic              wr_bg,
   input  logic [CNT_W-1:0]  wdata,
   output logic [CNT_W-1:0]  load_q,
   output logic [CNT_W-1:0]  val_q,
   output logic [CNT_W-1:0]  bg_q,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              zero_evt
);

   if (NARROW_W < 1 || NARROW_W >= CNT_W || CNT_W < CTRL_W) begin : g_bad_width
      $error("cdt_channel: need 1 <= NARROW_W < CNT_W and CNT_W >= CTRL_W");
   end

   localparam logic [CNT_W-1:0] NARROW_MASK = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
   localparam logic [CNT_W-1:0] ONE         = CNT_W'(1);

   logic [CNT_W-1:0] wmask, cur, nxt;
   logic             tick, step, at_zero, en_rise;
   cdt_mode_e        mode;

   assign wmask   = ctrl_q[CTRL_WIDE] ? '1 : NARROW_MASK;
   assign cur     = val_q & wmask;
   assign at_zero = (cur == '0);
   assign mode    = mode_of(ctrl_q);
   assign en_rise = wr_ctrl && wdata[CTRL_EN] && !ctrl_q[CTRL_EN];
   assign step    = ctrl_q[CTRL_EN] && tick && !wr_load;
   assign zero_evt = step && (cur == ONE);

   cdt_prescaler #(
      .MID_LOG (PS_MID_LOG),
      .MAX_LOG (PS_MAX_LOG)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (wr_load || en_rise),
      .run     (ctrl_q[CTRL_EN]),
      .div     (ctrl_q[CTRL_PS_HI:CTRL_PS_LO]),
      .tick    (tick)
   );

   always_comb begin
      if (!at_zero) begin
         nxt = cur - ONE;
      end else begin
         unique case (mode)
            MODE_PERIODIC: nxt = bg_q & wmask;
            MODE_ONESHOT:  nxt = '0;
            default:       nxt = wmask;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= '0;
         bg_q   <= '0;
         val_q  <= '1;
         ctrl_q <= '0;
      end else begin
         if (wr_load) begin
            load_q <= wdata;
            val_q  <= wdata & wmask;
         end else if (step) begin
            val_q  <= nxt;
         end
         if (wr_bg) bg_q <= wdata;
         if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0] & CTRL_KEEP;
         else if (zero_evt && mode == MODE_ONESHOT) ctrl_q[CTRL_EN] <= 1'b0;
      end
   end

   assert_load_sets_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_load |=> val_q == ($past(wdata) & $past(wmask)));

   assert_hold_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[CTRL_EN] && !wr_load) |=> $stable(val_q));

   assert_oneshot_disables_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_evt && mode == MODE_ONESHOT && !wr_ctrl) |=> !ctrl_q[CTRL_EN]);

   assert_bg_write_no_effect_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_bg && !wr_load && !step) |=> $stable(val_q));

endmodule

// File: rtl/cdt_irq_bank.sv
module cdt_irq_bank #(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mask_we,
   input  logic              clr_we,
   input  logic [NUM_CH-1:0] wbits,
   input  logic [NUM_CH-1:0] evt,
   output logic [NUM_CH-1:0] mask_q,
   output logic [NUM_CH-1:0] raw_q,
   output logic [NUM_CH-1:0] mis,
   output logic              irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= wbits;
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     raw_q[i] <= 1'b0;
         else if (evt[i])                raw_q[i] <= 1'b1;
         else if (clr_we && wbits[i])    raw_q[i] <= 1'b0;
      end

      assert_flag_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> raw_q[i]);

      assert_flag_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_we && wbits[i] && !evt[i]) |=> !raw_q[i]);
   end

   assign mis = raw_q & mask_q;
   assign irq = |mis;

endmodule

// File: rtl/cdt_timer_bank.sv
module cdt_timer_bank
   import cdt_pkg::*;
#(
   parameter int NUM_CH     = 4,
   parameter int CNT_W      = 32,
   parameter int NARROW_W   = 16,
   parameter int ADDR_W     = 8,
   parameter int PS_MID_LOG = 4,
   parameter int PS_MAX_LOG = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              irq
);

   localparam int WORD_W   = ADDR_W - 2;
   localparam int GRP_W    = WORD_W - 2;
   localparam int LAST_GRP = NUM_CH;

   if (NUM_CH < 1 || NUM_CH > CNT_W || LAST_GRP >= (1 << GRP_W)) begin : g_bad_map
      $error("cdt_timer_bank: channel count does not fit the address or data width");
   end

   logic [WORD_W-1:0] word;
   logic [GRP_W-1:0]  grp;
   logic [1:0]        sub;
   logic              sh_hit;

   assign word   = bus_addr[ADDR_W-1:2];
   assign grp    = word[WORD_W-1:2];
   assign sub    = word[1:0];
   assign sh_hit = (grp == '0);

   logic [NUM_CH-1:0] ch_hit, zero_evt, mask_q, raw_q, mis;
   logic [CNT_W-1:0]  ch_rd [NUM_CH];

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      logic [CNT_W-1:0]  load_q, val_q, bg_q;
      logic [CTRL_W-1:0] ctrl_q;

      assign ch_hit[n] = (grp == GRP_W'(n + 1));

      cdt_channel #(
         .CNT_W      (CNT_W),
         .NARROW_W   (NARROW_W),
         .PS_MID_LOG (PS_MID_LOG),
         .PS_MAX_LOG (PS_MAX_LOG)
      ) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_load  (bus_we && ch_hit[n] && sub == CH_LOAD),
         .wr_ctrl  (bus_we && ch_hit[n] && sub == CH_CTRL),
         .wr_bg    (bus_we && ch_hit[n] && sub == CH_BG),
         .wdata    (bus_wdata),
         .load_q   (load_q),
         .val_q    (val_q),
         .bg_q     (bg_q),
         .ctrl_q   (ctrl_q),
         .zero_evt (zero_evt[n])
      );

      always_comb begin
         unique case (sub)
            CH_LOAD: ch_rd[n] = load_q;
            CH_VAL:  ch_rd[n] = val_q;
            CH_CTRL: ch_rd[n] = CNT_W'(ctrl_q);
            default: ch_rd[n] = bg_q;
         endcase
      end

      assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (zero_evt[n] && mask_q[n] && !(bus_we && sh_hit && sub == SH_MASK)) |=> irq);
   end

   cdt_irq_bank #(
      .NUM_CH (NUM_CH)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask_we (bus_we && sh_hit && sub == SH_MASK),
      .clr_we  (bus_we && sh_hit && sub == SH_CLR),
      .wbits   (bus_wdata[NUM_CH-1:0]),
      .evt     (zero_evt),
      .mask_q  (mask_q),
      .raw_q   (raw_q),
      .mis     (mis),
      .irq     (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (sh_hit) begin
         unique case (sub)
            SH_MASK: bus_rdata = CNT_W'(mask_q);
            SH_RAW:  bus_rdata = CNT_W'(raw_q);
            SH_MIS:  bus_rdata = CNT_W'(mis);
            default: bus_rdata = '0;
         endcase
      end
      for (int n = 0; n < NUM_CH; n++) begin
         if (ch_hit[n]) bus_rdata = ch_rd[n];
      end
   end

   always_comb begin
      assert_mis_subset_R9: assert (!rst_n || (mis & ~raw_q) == '0);
   end

endmodule

// File: tb/cdt_timer_bank_bench.sv
`timescale 1ns/10ps
module cdt_timer_bank_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   typedef struct {
      bit          is_irq;
      logic [7:0]  addr;
      logic [31:0] exp;
      string       tag;
   } sb_item_t;

   sb_item_t sb_q[$];

   always #5 clk = ~clk;

   cdt_timer_bank u_cdt_timer_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   localparam logic [7:0] A_MASK = 8'h00, A_RAW = 8'h04, A_MIS = 8'h08, A_CLR = 8'h0C;

   function automatic logic [7:0] ca(input int ch, input int r);
      return 8'(8'h10 + 8'h10 * ch + 4 * r);
   endfunction

   // monitor: compares each queued expectation against the port
   initial begin
      forever begin
         wait (sb_q.size() != 0);
         begin
            sb_item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_irq ? {31'b0, irq} : bus_rdata;
            n_checks++;
            if (act !== it.exp) begin
               n_errors++;
               $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic exp_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
      sb_item_t it;
      bus_addr = a;
      #0.1;
      it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      #0.1;
   endtask

   task automatic exp_irq(input logic e, input string tag);
      sb_item_t it;
      it.is_irq = 1'b1; it.addr = 8'h00; it.exp = {31'b0, e}; it.tag = tag;
      sb_q.push_back(it);
      #0.1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      for (int c = 0; c < 4; c++) begin
         exp_reg(ca(c, 0), 32'h0, "R1 load");
         exp_reg(ca(c, 1), 32'hFFFF_FFFF, "R1 value");
         exp_reg(ca(c, 2), 32'h0, "R1 ctrl");
         exp_reg(ca(c, 3), 32'h0, "R1 bg");
      end
      idle(1);
      exp_reg(A_MASK, 0, "R1 mask");
      exp_reg(A_RAW, 0, "R1 raw");
      exp_reg(A_MIS, 0, "R1 mis");
      exp_reg(A_CLR, 0, "R1 clr");
      exp_irq(1'b0, "R1 irq");

      // ch0: divide by 1, 32-bit free-running
      wr(ca(0, 0), 32'd10);
      wr(ca(0, 2), 32'h82);
      exp_reg(ca(0, 1), 32'd10, "R3 value after load");
      idle(3);
      exp_reg(ca(0, 1), 32'd7, "R4 div1 steps");
      idle(7);
      exp_reg(ca(0, 1), 32'd0, "R8 reach zero");
      exp_reg(A_RAW, 32'h1, "R8 raw set");
      exp_irq(1'b0, "R9 masked off");
      idle(1);
      exp_reg(ca(0, 1), 32'hFFFF_FFFF, "R5 wrap 32");
      wr(A_MASK, 32'h1);
      exp_reg(A_MIS, 32'h1, "R9 mis");
      exp_irq(1'b1, "R9 irq high");
      wr(A_CLR, 32'h1);
      exp_reg(A_RAW, 32'h0, "R8 w1c");
      exp_irq(1'b0, "R9 irq low");
      wr(ca(0, 2), 32'h0);
      idle(5);
      exp_reg(ca(0, 1), 32'hFFFF_FFFC, "R10 hold when off");

      // ch1: divide by 16, periodic
      wr(ca(1, 3), 32'd2);
      exp_reg(ca(1, 1), 32'hFFFF_FFFF, "R6 bg write no effect");
      exp_reg(ca(1, 3), 32'd2, "R2 bg readback");
      wr(ca(1, 0), 32'd3);
      wr(ca(1, 2), 32'hC6);
      exp_reg(ca(1, 1), 32'd3, "R3 load");
      idle(15);
      exp_reg(ca(1, 1), 32'd3, "R4 div16 not yet");
      idle(1);
      exp_reg(ca(1, 1), 32'd2, "R4 div16 first tick");
      idle(32);
      exp_reg(ca(1, 1), 32'd0, "R6 zero");
      exp_reg(A_RAW, 32'h2, "R8 raw ch1");
      idle(16);
      exp_reg(ca(1, 1), 32'd2, "R6 reload");
      wr(ca(1, 3), 32'd5);
      idle(47);
      exp_reg(ca(1, 1), 32'd5, "R6 staged reload used");
      wr(ca(1, 2), 32'h0);
      exp_reg(ca(0, 1), 32'hFFFF_FFFC, "R11 ch0 untouched");

      // ch2: code 11 (/256), one-shot, 16-bit
      wr(ca(2, 0), 32'h1234_0002);
      exp_reg(ca(2, 1), 32'h2, "R3 narrow mask");
      exp_reg(ca(2, 0), 32'h1234_0002, "R2 load readback");
      wr(ca(2, 2), 32'h8D);
      idle(255);
      exp_reg(ca(2, 1), 32'h2, "R4 div256 not yet");
      idle(1);
      exp_reg(ca(2, 1), 32'h1, "R4 div256 tick");
      idle(256);
      exp_reg(ca(2, 1), 32'h0, "R7 reach zero");
      exp_reg(ca(2, 2), 32'h0D, "R7 enable cleared");
      exp_reg(A_RAW, 32'h6, "R8 raw ch2");
      idle(300);
      exp_reg(ca(2, 1), 32'h0, "R7 stays zero");

      // ch3: divide by 1, free-running, 16-bit
      wr(ca(3, 0), 32'd1);
      wr(ca(3, 2), 32'h80);
      idle(1);
      exp_reg(ca(3, 1), 32'h0, "R5 zero");
      exp_reg(A_RAW, 32'hE, "R8 raw ch3");
      idle(1);
      exp_reg(ca(3, 1), 32'h0000_FFFF, "R5 wrap 16");
      wr(ca(3, 2), 32'h0);

      // mask and combined line
      wr(A_MASK, 32'h4);
      exp_reg(A_MIS, 32'h4, "R9 mis ch2");
      exp_irq(1'b1, "R9 irq ch2");
      wr(A_CLR, 32'h4);
      exp_reg(A_RAW, 32'hA, "R8 clear one bit");
      exp_reg(A_MIS, 32'h0, "R9 mis empty");
      exp_irq(1'b0, "R9 irq low");
      wr(A_MASK, 32'h8);
      exp_irq(1'b1, "R9 irq ch3");
      exp_reg(A_MASK, 32'h8, "R2 mask readback");
      wr(A_CLR, 32'hF);
      exp_reg(A_RAW, 32'h0, "R8 clear all");
      exp_irq(1'b0, "R9 irq cleared");

      // set wins over clear in the same cycle
      wr(ca(0, 0), 32'd2);
      wr(ca(0, 2), 32'h82);
      idle(1);
      wr(A_CLR, 32'h1);
      exp_reg(A_RAW, 32'h1, "R8 set beats clear");
      wr(A_CLR, 32'h1);
      exp_reg(A_RAW, 32'h0, "R8 later clear");
      wr(ca(0, 2), 32'h0);

      // control readback and code 10
      wr(ca(3, 2), 32'hFF);
      exp_reg(ca(3, 2), 32'hCF, "R2 ctrl kept bits");
      wr(ca(3, 2), 32'h0);
      wr(ca(3, 0), 32'd1);
      wr(ca(3, 2), 32'h88);
      idle(255);
      exp_reg(ca(3, 1), 32'h1, "R4 code10 not yet");
      idle(1);
      exp_reg(ca(3, 1), 32'h0, "R4 code10 tick");

      idle(2);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule